// File: doc/BRIEF.md
# Reference Clock Select and Lock Monitor

This block picks the reference against which a recovered line clock is judged, and reports whether that clock has drifted out of lock. Every input is oversampled in one fast system clock domain. Three candidate primary references exist, one per line rate, and a two-bit line-mode input picks one of them. When the chosen primary is toggling it is the reference. When it sits high, the transmit clock input takes its place. When neither gives a usable clock, no reference is declared and the lock decision freezes.

The block counts recovered-clock rising edges over a window of a fixed number of reference rising edges. The count is compared against the window length. An absolute offset at or above an upper limit declares loss of lock. An offset at or below a lower limit clears it. Offsets between the two limits leave the flag unchanged. With the default window, the limits sit near 7900 ppm and 7700 ppm. Every change of the loss-of-lock flag can latch a sticky interrupt, which a one-cycle clear pulse removes.

Top module: `refclk_lock_monitor`

## Requirements
- R1: After reset `lol` and `lol_irq` are low, and `ref_ok` stays low until a reference has been seen toggling.
- R2: A reference input counts as toggling while it shows a rising edge at least once in every IDLE_LIMIT system clocks. A toggling selected primary is the reference, which gives `ref_ok`=1 and `ref_from_tx`=0. The line-mode code selects the primary: 0 gives `pri_ref_ds3`, 1 gives `pri_ref_e3`, 2 gives `pri_ref_sts1`, and 3 falls back to `pri_ref_ds3`.
- R3: Primaries not selected by `line_mode` have no effect. If the selected primary stops toggling while another primary still toggles, `ref_ok` falls.
- R4: A selected primary sampled high for IDLE_LIMIT consecutive system clocks counts as stuck high. In that case, while `tx_clk` toggles, the transmit clock is the reference, which gives `ref_ok`=1 and `ref_from_tx`=1.
- R5: With no usable reference, `ref_ok` is 0 and `lol` keeps its value whatever the recovered clock does. This covers a selected primary stuck low, and a selected primary stuck high with `tx_clk` not toggling.
- R6: Each measurement spans WINDOW reference rising edges. The offset is |recovered rising edges − WINDOW|. An offset of at least SET_OFS sets `lol` one cycle after the window closes.
- R7: An offset of at most CLR_OFS clears `lol`. An offset strictly between CLR_OFS and SET_OFS leaves `lol` unchanged in either state.
- R8: Any change of `lol` sets `lol_irq` in the same cycle when `lol_irq_en` is high. `lol_irq` then stays high until a `lol_irq_clr` pulse. A change in the clearing cycle wins over the clear. With the enable low, `lol_irq` never rises.
- R9: The offset is symmetric, so a recovered clock that runs slow by SET_OFS or more edges per window also sets `lol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice any sampled clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_mode | input | 2 | Line rate code that selects the primary reference |
| pri_ref_ds3 | input | 1 | Primary reference for line mode 0 (and 3) |
| pri_ref_e3 | input | 1 | Primary reference for line mode 1 |
| pri_ref_sts1 | input | 1 | Primary reference for line mode 2 |
| tx_clk | input | 1 | Transmit clock, used as the fallback reference |
| rec_clk | input | 1 | Recovered clock under test |
| lol_irq_en | input | 1 | Interrupt enable for loss-of-lock changes |
| lol_irq_clr | input | 1 | One-cycle clear of the sticky interrupt |
| ref_ok | output | 1 | A usable reference is present |
| ref_from_tx | output | 1 | The transmit clock is the current reference |
| lol | output | 1 | Loss-of-lock flag |
| lol_irq | output | 1 | Sticky interrupt on any change of `lol` |

## Verification
An idle or stuck-high counter that is off shows at `ref_ok` and `ref_from_tx`. The error becomes visible within about IDLE_LIMIT plus three system clocks of the stimulus change. A measurement counter that drifts, or a window that closes at the wrong edge, shifts the offset. That error shows only at `lol` and `lol_irq`, one cycle after a window closes, so it takes up to two windows to appear. Rates are therefore chosen to give exact per-window edge counts, on both sides of each limit and inside the hold band. A missing restart on source loss shows as `lol` moving while `ref_ok` is low.

// File: rtl/refclk_lock_pkg.sv
// Shared types for the reference select and lock monitor.
// Assumes line_mode is quasi-static relative to the system clock.
package refclk_lock_pkg;

    typedef enum logic [1:0] {
        LINE_DS3  = 2'd0,
        LINE_E3   = 2'd1,
        LINE_STS1 = 2'd2,
        LINE_RSVD = 2'd3
    } line_mode_e;

    // Slot index of the transmit clock in the monitored source vector.
    localparam int SRC_TX = 3;

    // Map a line-mode code to the slot of its primary reference.
    function automatic logic [1:0] primary_slot(input logic [1:0] m);
        case (line_mode_e'(m))
            LINE_E3:   return 2'd1;
            LINE_STS1: return 2'd2;
            default:   return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/edge_activity_mon.sv
// Synchronises one slow clock input into the system domain, flags its
// rising edges, and classifies it as toggling or stuck high.
// Assumes the input is slower than half the system clock rate.
module edge_activity_mon #(
    parameter int IDLE_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic alive,
    output logic stuck_hi
);
    localparam int CW = $clog2(IDLE_LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);

    logic s_meta, s_sync, s_last;
    logic [CW-1:0] idle_cnt;
    logic [CW-1:0] hi_run;

    // Two-flop synchroniser plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_meta <= 1'b0;
            s_sync <= 1'b0;
            s_last <= 1'b0;
        end else begin
            s_meta <= pin_in;
            s_sync <= s_meta;
            s_last <= s_sync;
        end
    end

    assign rise = s_sync & ~s_last;

    // Cycles since the last rising edge, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)              idle_cnt <= LIM;
        else if (rise)           idle_cnt <= '0;
        else if (idle_cnt != LIM) idle_cnt <= idle_cnt + 1'b1;
    end

    // Consecutive cycles sampled high, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)             hi_run <= '0;
        else if (!s_sync)       hi_run <= '0;
        else if (hi_run != LIM) hi_run <= hi_run + 1'b1;
    end

    assign alive    = (idle_cnt != LIM);
    assign stuck_hi = (hi_run == LIM);

endmodule

// File: rtl/freq_window_meter.sv
// Counts recovered-clock edges across a window of reference edges and
// emits the absolute count offset with a one-cycle done strobe.
// Assumes restart is asserted whenever the reference source changes.
module freq_window_meter #(
    parameter int WINDOW = 131072,
    parameter int REF_W  = 17,
    parameter int REC_W  = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             ref_rise,
    input  logic             rec_rise,
    output logic             done,
    output logic [REC_W-1:0] offset
);
    localparam logic [REF_W-1:0] LAST_REF = REF_W'(WINDOW - 1);
    localparam logic [REC_W:0]   WIN_X    = (REC_W+1)'(WINDOW);

    logic [REF_W-1:0] ref_cnt;
    logic [REC_W-1:0] rec_cnt;
    logic [REC_W:0]   rec_total;
    logic [REC_W:0]   abs_diff;
    logic             closing;

    assign closing   = ref_rise && (ref_cnt == LAST_REF);
    assign rec_total = {1'b0, rec_cnt} + (REC_W+1)'(rec_rise);
    assign abs_diff  = (rec_total >= WIN_X) ? (rec_total - WIN_X) : (WIN_X - rec_total);

    // Reference edge counter that defines the window.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) ref_cnt <= '0;
        else if (closing)      ref_cnt <= '0;
        else if (ref_rise)     ref_cnt <= ref_cnt + 1'b1;
    end

    // Recovered edge counter, saturating so a runaway clock cannot wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)               rec_cnt <= '0;
        else if (closing)                    rec_cnt <= '0;
        else if (rec_rise && rec_cnt != '1)  rec_cnt <= rec_cnt + 1'b1;
    end

    // Result register: offset and strobe for one cycle per window.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            done   <= 1'b0;
            offset <= '0;
        end else begin
            done <= closing;
            if (closing) offset <= abs_diff[REC_W-1:0];
        end
    end

endmodule

// File: rtl/refclk_lock_monitor.sv
// Top level: chooses the reference from the line-mode primary or the
// transmit clock fallback, measures the recovered clock against it, and
// keeps a hysteretic loss-of-lock flag with a sticky maskable interrupt.
// Assumes every input is a slow signal oversampled by clk.
module refclk_lock_monitor
    import refclk_lock_pkg::*;
#(
    parameter int WINDOW     = 131072,
    parameter int SET_OFS    = 1036,
    parameter int CLR_OFS    = 1009,
    parameter int IDLE_LIMIT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_mode,
    input  logic       pri_ref_ds3,
    input  logic       pri_ref_e3,
    input  logic       pri_ref_sts1,
    input  logic       tx_clk,
    input  logic       rec_clk,
    input  logic       lol_irq_en,
    input  logic       lol_irq_clr,
    output logic       ref_ok,
    output logic       ref_from_tx,
    output logic       lol,
    output logic       lol_irq
);
    localparam int REF_W = $clog2(WINDOW);
    localparam int REC_W = $clog2(WINDOW) + 6;
    localparam logic [REC_W-1:0] SET_X = REC_W'(SET_OFS);
    localparam logic [REC_W-1:0] CLR_X = REC_W'(CLR_OFS);

    logic [3:0] src_pins, src_rise, src_alive, src_stuck;
    logic [1:0] pslot;
    logic       use_tx, ref_valid, ref_rise_sel, restart;
    logic [2:0] sel_key, sel_key_q;
    logic       rec_s1, rec_s2, rec_s3, rec_rise;
    logic             win_done;
    logic [REC_W-1:0] win_offset;
    logic       lol_next, lol_change;

    assign src_pins = {tx_clk, pri_ref_sts1, pri_ref_e3, pri_ref_ds3};

    for (genvar g = 0; g < 4; g++) begin : g_src
        edge_activity_mon #(.IDLE_LIMIT(IDLE_LIMIT)) u_mon (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_in   (src_pins[g]),
            .rise     (src_rise[g]),
            .alive    (src_alive[g]),
            .stuck_hi (src_stuck[g])
        );
    end

    // Synchronise the recovered clock and detect its rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_s1 <= 1'b0;
            rec_s2 <= 1'b0;
            rec_s3 <= 1'b0;
        end else begin
            rec_s1 <= rec_clk;
            rec_s2 <= rec_s1;
            rec_s3 <= rec_s2;
        end
    end
    assign rec_rise = rec_s2 & ~rec_s3;

    // Source selection: toggling primary first, else tx if primary is high.
    always_comb begin
        pslot        = primary_slot(line_mode);
        use_tx       = !src_alive[pslot] && src_stuck[pslot] && src_alive[SRC_TX];
        ref_valid    = src_alive[pslot] || use_tx;
        ref_rise_sel = use_tx ? src_rise[SRC_TX] : src_rise[pslot];
        sel_key      = {use_tx, pslot};
        restart      = !ref_valid || (sel_key != sel_key_q);
    end

    // Remember the last selection so a switch restarts the window.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_key_q <= '0;
        else        sel_key_q <= sel_key;
    end

    freq_window_meter #(.WINDOW(WINDOW), .REF_W(REF_W), .REC_W(REC_W)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .ref_rise (ref_rise_sel),
        .rec_rise (rec_rise),
        .done     (win_done),
        .offset   (win_offset)
    );

    // Hysteresis decision on each finished window while a reference exists.
    always_comb begin
        lol_next = lol;
        if (win_done && ref_valid) begin
            if (win_offset >= SET_X)      lol_next = 1'b1;
            else if (win_offset <= CLR_X) lol_next = 1'b0;
        end
        lol_change = (lol_next != lol);
    end

    // Loss-of-lock flag and sticky interrupt; a change beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lol     <= 1'b0;
            lol_irq <= 1'b0;
        end else begin
            lol <= lol_next;
            if (lol_change && lol_irq_en) lol_irq <= 1'b1;
            else if (lol_irq_clr)         lol_irq <= 1'b0;
        end
    end

    assign ref_ok      = ref_valid;
    assign ref_from_tx = use_tx;

endmodule

// File: rtl/refclk_lock_checker.sv
// Port-level properties of the lock monitor, attached by bind.
// Assumes synchronous active-low reset on clk.
module refclk_lock_checker (
    input logic clk,
    input logic rst_n,
    input logic ref_ok,
    input logic lol,
    input logic lol_irq,
    input logic lol_irq_en,
    input logic lol_irq_clr
);
    p_lol_rise_needs_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lol) |-> $past(ref_ok));

    p_lol_frozen_no_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_ok |=> $stable(lol));

    p_irq_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((lol != $past(lol)) && $past(lol_irq_en)) |-> lol_irq);

    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lol_irq) |-> $past(lol_irq_en));

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lol_irq_clr) && (lol == $past(lol))) |-> !lol_irq);

    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lol_irq && !lol_irq_clr) |=> lol_irq);
endmodule

bind refclk_lock_monitor refclk_lock_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_ok      (ref_ok),
    .lol         (lol),
    .lol_irq     (lol_irq),
    .lol_irq_en  (lol_irq_en),
    .lol_irq_clr (lol_irq_clr)
);

// File: tb/refclk_lock_monitor_test.sv
// Bench: references toggle with an 8-cycle period, so a 64-edge window lasts
// 512 cycles; the recovered clock comes from an accumulator that gives
// exactly 64+rec_d edges in any 512 consecutive cycles.
module refclk_lock_monitor_test;
    localparam int WIN = 64;
    localparam int SETO = 4;
    localparam int CLRO = 2;
    localparam int SETTLE = 1700;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] line_mode = 2'd0;
    logic pri_ref_ds3 = 1'b0, pri_ref_e3 = 1'b0, pri_ref_sts1 = 1'b0;
    logic tx_clk = 1'b0, rec_clk = 1'b0;
    logic lol_irq_en = 1'b0, lol_irq_clr = 1'b0;
    logic ref_ok, ref_from_tx, lol, lol_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Per-source control: 0 toggle, 1 held high, 2 held low.
    int ctl [4] = '{2, 2, 2, 2};
    int phase = 0;
    int acc = 0;
    int rec_d = 0;

    refclk_lock_monitor #(.WINDOW(WIN), .SET_OFS(SETO), .CLR_OFS(CLRO), .IDLE_LIMIT(64)) uut (
        .clk(clk), .rst_n(rst_n), .line_mode(line_mode),
        .pri_ref_ds3(pri_ref_ds3), .pri_ref_e3(pri_ref_e3), .pri_ref_sts1(pri_ref_sts1),
        .tx_clk(tx_clk), .rec_clk(rec_clk),
        .lol_irq_en(lol_irq_en), .lol_irq_clr(lol_irq_clr),
        .ref_ok(ref_ok), .ref_from_tx(ref_from_tx), .lol(lol), .lol_irq(lol_irq)
    );

    always #5 clk = ~clk;

    function automatic logic level(input int c, input int ph);
        if (c == 0) return ph[2];
        return (c == 1);
    endfunction

    // Expected loss-of-lock after a steady offset d, from the previous value.
    function automatic logic exp_lol(input logic prev, input int d);
        int a = (d < 0) ? -d : d;
        if (a >= SETO) return 1'b1;
        if (a <= CLRO) return 1'b0;
        return prev;
    endfunction

    // Drive the stimulus away from the sampling edge.
    always @(negedge clk) begin
        phase = phase + 1;
        pri_ref_ds3  = level(ctl[0], phase);
        pri_ref_e3   = level(ctl[1], phase);
        pri_ref_sts1 = level(ctl[2], phase);
        tx_clk       = level(ctl[3], phase);
        acc = acc + 64 + rec_d;
        if (acc >= 512) begin
            acc = acc - 512;
            rec_clk = 1'b1;
        end else begin
            rec_clk = 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        lol_irq_clr = 1'b1;
        @(negedge clk);
        lol_irq_clr = 1'b0;
        wait_cyc(2);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic prev;
        void'($urandom(32'd4242));
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1: reset state
        chk("R1", "lol", lol, 1'b0);
        chk("R1", "irq", lol_irq, 1'b0);
        chk("R1", "ref_ok", ref_ok, 1'b0);

        // R2: DS3 primary toggling, on-frequency recovered clock
        lol_irq_en = 1'b1;
        ctl = '{0, 0, 0, 0};
        line_mode = 2'd0;
        rec_d = 0;
        wait_cyc(SETTLE);
        chk("R2", "ref_ok", ref_ok, 1'b1);
        chk("R2", "ref_from_tx", ref_from_tx, 1'b0);
        chk("R2", "lol", lol, 1'b0);
        chk("R2", "irq", lol_irq, 1'b0);

        // R3: mode E3 uses only pri_ref_e3
        ctl = '{2, 0, 2, 2};
        line_mode = 2'd1;
        wait_cyc(300);
        chk("R3", "ref_ok e3 only", ref_ok, 1'b1);
        ctl = '{0, 2, 0, 0};
        wait_cyc(300);
        chk("R3", "ref_ok e3 stopped", ref_ok, 1'b0);

        // R2: code 3 falls back to the DS3 primary
        line_mode = 2'd3;
        wait_cyc(300);
        chk("R2", "ref_ok mode3", ref_ok, 1'b1);

        // R4: DS3 primary held high, tx toggling
        line_mode = 2'd0;
        ctl = '{1, 2, 2, 0};
        wait_cyc(300);
        chk("R4", "ref_ok", ref_ok, 1'b1);
        chk("R4", "ref_from_tx", ref_from_tx, 1'b1);

        // R5: primary high and tx absent, far-off recovered clock
        ctl = '{1, 2, 2, 2};
        rec_d = 10;
        wait_cyc(SETTLE);
        chk("R5", "ref_ok", ref_ok, 1'b0);
        chk("R5", "lol held", lol, 1'b0);
        ctl = '{2, 2, 2, 0};
        wait_cyc(SETTLE);
        chk("R5", "stuck low ref_ok", ref_ok, 1'b0);
        chk("R5", "stuck low lol", lol, 1'b0);

        // R6/R8: reference back, fast recovered clock sets lol and irq
        ctl = '{0, 2, 2, 2};
        rec_d = 6;
        wait_cyc(SETTLE);
        chk("R6", "lol set", lol, 1'b1);
        chk("R8", "irq set", lol_irq, 1'b1);

        // R7/R8: hold band keeps lol set; irq stays sticky
        rec_d = 3;
        wait_cyc(SETTLE);
        chk("R7", "hold high", lol, 1'b1);
        chk("R8", "irq sticky", lol_irq, 1'b1);
        pulse_clr();
        chk("R8", "irq cleared", lol_irq, 1'b0);

        // R7: clear, then hold band keeps lol low
        rec_d = 1;
        wait_cyc(SETTLE);
        chk("R7", "cleared", lol, 1'b0);
        chk("R8", "irq on clear", lol_irq, 1'b1);
        pulse_clr();
        rec_d = 3;
        wait_cyc(SETTLE);
        chk("R7", "hold low", lol, 1'b0);

        // R9: slow recovered clock sets lol; R8 masked interrupt
        lol_irq_en = 1'b0;
        rec_d = -6;
        wait_cyc(SETTLE);
        chk("R9", "slow sets lol", lol, 1'b1);
        chk("R8", "masked irq", lol_irq, 1'b0);
        rec_d = 0;
        wait_cyc(SETTLE);
        chk("R7", "back to lock", lol, 1'b0);

        // Random trials over modes, fallback path, rates and enables
        prev = lol;
        for (int t = 0; t < 30; t++) begin
            int m = $urandom % 4;
            int slot = (m == 3) ? 0 : m;
            bit via_tx = $urandom % 2;
            bit en = $urandom % 2;
            int d;
            logic e_lol;
            if ($urandom % 2) d = int'($urandom % 5) - 2;
            else              d = 4 + int'($urandom % 9);
            pulse_clr();
            for (int k = 0; k < 3; k++) ctl[k] = ($urandom % 2) ? 0 : 2;
            ctl[slot] = via_tx ? 1 : 0;
            ctl[3] = 0;
            line_mode = 2'(m);
            lol_irq_en = en;
            rec_d = d;
            wait_cyc(SETTLE);
            e_lol = exp_lol(prev, d);
            chk("R4", "rand ref_from_tx", ref_from_tx, via_tx);
            chk("R6", "rand lol", lol, e_lol);
            chk("R8", "rand irq", lol_irq, en && (e_lol != prev));
            prev = e_lol;
        end
        summary();
    end
endmodule